// File: doc/BRIEF.md
# Stochastic Binary Weight Array

This block keeps a grid of single-bit weights, `ROWS` rows by `COLS` columns, and runs one of two kinds of pass over it. A training pass walks the columns in ascending order. For each column it turns the column's input fraction, scaled by a learning rate, into a random write bit. It then sets, clears or leaves that column's weight in every row according to the row's ternary code. A recognition pass walks the same columns and adds up, for every row, the inputs of the columns whose weight is high. No weight changes during recognition.

A pass starts with a one-cycle `start` pulse while the block is idle. All operands are captured on that edge. The block spends one cycle per column and then raises `done` for one cycle. After a recognition pass, `sum_valid` rises together with `done` and the row sums appear on `sum_out`. The random draws come from an internal 8-bit LFSR whose sequence is fixed by its polynomial and seed, so a host model can predict every update exactly.

Top module: `bsw_array`

## Requirements
- R1: Synchronous reset clears every weight to low, seeds the LFSR with 8'h01 and drives `done`, `sum_valid` and `sum_out` to zero.
- R2: The LFSR holds 8 bits and steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]}. A training pass steps it once per column, in ascending column order, and each column uses the state from before its own step. A recognition pass leaves it unchanged.
- R3: In training, the write bit of column c is 1 exactly when the LFSR value is below floor(learn_rate * in[c] / 256). Input c is `in_vec[8c+7:8c]`. A zero input or a zero rate therefore never writes.
- R4: The code of row r is `row_codes[2r+1:2r]`, where 2'b01 means potentiate, 2'b11 means depress, and 2'b00 or 2'b10 means hold. When the write bit is 1, potentiate sets the weight to 1 and depress clears it to 0. A write bit of 0 or a hold code leaves the weight as it was.
- R5: In a recognition pass no weight changes, whatever the row codes are.
- R6: A recognition pass yields, for each row r, the sum of in[c] over all columns whose weight is 1, on `sum_out[r*SW +: SW]` with SW = 8 + clog2(COLS+1).
- R7: A `start` accepted on edge E gives a one-cycle `done` after edge E+COLS. `sum_valid` is high in that same cycle after a recognition pass and stays low after a training pass.
- R8: `start` is ignored while a pass runs. Operands are taken at the accepting edge, so later changes to `train_mode`, `in_vec`, `learn_rate` or `row_codes` have no effect on that pass.
- R9: `sum_out` keeps its value until the next recognition pass completes. Training passes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_mode | input | 1 | 1 selects a training pass, 0 a recognition pass; sampled with `start` |
| start | input | 1 | Launches a pass when the block is idle |
| in_vec | input | COLS*8 | Per-column unsigned 8-bit input fractions |
| learn_rate | input | 8 | Unsigned 8-bit learning-rate fraction |
| row_codes | input | ROWS*2 | Per-row ternary update code |
| done | output | 1 | One-cycle pass-complete strobe |
| sum_valid | output | 1 | Row sums on `sum_out` are fresh (recognition only) |
| sum_out | output | ROWS*SW | Registered row sums, row 0 in the low bits |

## Verification
A wrong weight is invisible at the ports until the next recognition pass. There it shows up within COLS+1 cycles as a row sum off by that column's input. Placing distinct powers of two on the columns turns every row sum into a direct readout of the row's weights. A wrong LFSR step or threshold is harder to see. It only changes which weights a later training pass writes, so it surfaces a full training pass plus a recognition pass after the faulty draw, as a row whose bits disagree with the reference model. Errors in the sequencer show up at once as `done` or `sum_valid` in the wrong cycle.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  localparam int FRAC_W = 8;
  localparam logic [FRAC_W-1:0] LFSR_SEED = 8'h01;

  typedef enum logic [1:0] {
    CODE_HOLD = 2'b00,
    CODE_POT  = 2'b01,
    CODE_RSV  = 2'b10,
    CODE_DEP  = 2'b11
  } row_code_e;

  // maximal-length polynomial x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [FRAC_W-1:0] lfsr_advance(input logic [FRAC_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/bsw_lfsr.sv
module bsw_lfsr
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [FRAC_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst)       state <= LFSR_SEED;
    else if (step) state <= lfsr_advance(state);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0) else $error("lfsr locked at zero"); // R2
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state)) else $error("lfsr moved without step"); // R2

endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl #(
  parameter  int COLS = 4,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic [CW-1:0] col,
  output logic          last_col,
  output logic          done
);

  assign accept   = start && !busy;
  assign last_col = busy && (col == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      col  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_col;
      if (accept) begin
        busy <= 1'b1;
        col  <= '0;
      end else if (busy) begin
        if (last_col) busy <= 1'b0;
        else          col  <= col + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_col) |=> (busy && col == $past(col) + 1'b1)) else $error("column skip"); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last_col) |=> (col != '0)) else $error("restart while busy"); // R8

endmodule

// File: rtl/bsw_row.sv
module bsw_row
  import bsw_pkg::*;
#(
  parameter  int COLS = 4,
  parameter  int SW   = 11,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              proc,
  input  logic              train,
  input  row_code_e         code,
  input  logic [CW-1:0]     col,
  input  logic              wbit,
  input  logic [FRAC_W-1:0] in_val,
  output logic [SW-1:0]     acc_nxt
);

  logic [COLS-1:0] w_q;
  logic [SW-1:0]   acc_q;

  always_comb begin
    acc_nxt = acc_q;
    if (accept)
      acc_nxt = '0;
    else if (proc && !train && w_q[col])
      acc_nxt = acc_q + {{(SW-FRAC_W){1'b0}}, in_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      acc_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (proc && train && wbit) begin
        case (code)
          CODE_POT: w_q[col] <= 1'b1;
          CODE_DEP: w_q[col] <= 1'b0;
          default:  ;
        endcase
      end
    end
  end

  AST_RECOG_W_STABLE: assert property (@(posedge clk) disable iff (rst)
    (proc && !train) |=> $stable(w_q)) else $error("weight moved in recognition"); // R5
  AST_NO_WRITE_BIT: assert property (@(posedge clk) disable iff (rst)
    (proc && train && !wbit) |=> $stable(w_q)) else $error("weight moved without write bit"); // R3
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    (proc && (code == CODE_HOLD || code == CODE_RSV)) |=> $stable(w_q)) else $error("hold code wrote"); // R4
  AST_POT_SETS: assert property (@(posedge clk) disable iff (rst)
    (proc && train && wbit && code == CODE_POT) |=> w_q[$past(col)]) else $error("potentiate missed"); // R4
  AST_DEP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (proc && train && wbit && code == CODE_DEP) |=> !w_q[$past(col)]) else $error("depress missed"); // R4

endmodule

// File: rtl/bsw_array.sv
module bsw_array
  import bsw_pkg::*;
#(
  parameter  int ROWS = 4,
  parameter  int COLS = 4,
  localparam int SW   = FRAC_W + $clog2(COLS + 1),
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     train_mode,
  input  logic                     start,
  input  logic [COLS*FRAC_W-1:0]   in_vec,
  input  logic [FRAC_W-1:0]        learn_rate,
  input  logic [ROWS*2-1:0]        row_codes,
  output logic                     done,
  output logic                     sum_valid,
  output logic [ROWS*SW-1:0]       sum_out
);

  logic                   accept, busy, last_col;
  logic [CW-1:0]          col;
  logic                   train_q;
  logic [COLS*FRAC_W-1:0] in_q;
  logic [FRAC_W-1:0]      rate_q;
  logic [ROWS*2-1:0]      code_q;
  logic [FRAC_W-1:0]      lfsr_q, in_col, thr;
  logic [2*FRAC_W-1:0]    prod;
  logic                   wbit;
  logic [ROWS*SW-1:0]     acc_all;

  // operand capture on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      train_q <= 1'b0;
      in_q    <= '0;
      rate_q  <= '0;
      code_q  <= '0;
    end else if (accept) begin
      train_q <= train_mode;
      in_q    <= in_vec;
      rate_q  <= learn_rate;
      code_q  <= row_codes;
    end
  end

  bsw_ctrl #(.COLS(COLS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .accept(accept), .busy(busy),
    .col(col), .last_col(last_col), .done(done)
  );

  bsw_lfsr u_lfsr (
    .clk(clk), .rst(rst), .step(busy && train_q), .state(lfsr_q)
  );

  assign in_col = in_q[col*FRAC_W +: FRAC_W];
  assign prod   = {{FRAC_W{1'b0}}, rate_q} * {{FRAC_W{1'b0}}, in_col};
  assign thr    = prod[2*FRAC_W-1:FRAC_W];
  assign wbit   = train_q && (lfsr_q < thr);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    row_code_e code_eff;
    assign code_eff = train_q ? row_code_e'(code_q[r*2 +: 2]) : CODE_HOLD;

    bsw_row #(.COLS(COLS), .SW(SW)) u_row (
      .clk(clk), .rst(rst), .accept(accept), .proc(busy), .train(train_q),
      .code(code_eff), .col(col), .wbit(wbit), .in_val(in_col),
      .acc_nxt(acc_all[r*SW +: SW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_out   <= '0;
    end else begin
      sum_valid <= last_col && !train_q;
      if (last_col && !train_q) sum_out <= acc_all;
    end
  end

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> done) else $error("sum_valid without done"); // R7
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sum_valid |-> $stable(sum_out)) else $error("sum_out changed outside a result"); // R9
  AST_NO_WBIT_RECOG: assert property (@(posedge clk) disable iff (rst)
    (busy && !train_q) |-> !wbit) else $error("write bit in recognition"); // R5

endmodule

// File: tb/test_bsw_array.sv
module test_bsw_array;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int SW   = 8 + $clog2(COLS + 1);
  localparam logic [1:0] C_HOLD = 2'b00, C_POT = 2'b01, C_RSV = 2'b10, C_DEP = 2'b11;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 train_mode = 1'b0;
  logic                 start = 1'b0;
  logic [COLS*8-1:0]    in_vec = '0;
  logic [7:0]           learn_rate = '0;
  logic [ROWS*2-1:0]    row_codes = '0;
  logic                 done, sum_valid;
  logic [ROWS*SW-1:0]   sum_out;

  bsw_array #(.ROWS(ROWS), .COLS(COLS)) i_bsw_array (
    .clk(clk), .rst(rst), .train_mode(train_mode), .start(start),
    .in_vec(in_vec), .learn_rate(learn_rate), .row_codes(row_codes),
    .done(done), .sum_valid(sum_valid), .sum_out(sum_out)
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  logic [ROWS*SW-1:0] q_sum[$];
  string              q_tag[$];
  logic [ROWS*SW-1:0] last_sums = '0;
  logic [7:0]         m_lfsr = 8'h01;
  bit                 m_w[ROWS][COLS];
  logic [31:0]        seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R2: reference LFSR step from the requirement
  function automatic logic [7:0] ref_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sum_valid) begin
      if (q_sum.size() == 0) begin
        check(1'b0, "R7 unexpected sum_valid", 64'(sum_valid), 64'd0);
      end else begin
        logic [ROWS*SW-1:0] e;
        string t;
        e = q_sum.pop_front();
        t = q_tag.pop_front();
        check(sum_out == e, t, 64'(sum_out), 64'(e));
      end
      last_sums = sum_out;
    end
  end

  task automatic run_pass(input bit trn, input logic [COLS*8-1:0] iv, input logic [7:0] rt,
                          input logic [ROWS*2-1:0] cv, input bit disturb, input string tag);
    // model first, from the requirements
    if (trn) begin
      for (int c = 0; c < COLS; c++) begin
        logic [15:0] p;
        bit wb;
        p = 16'(rt) * 16'(iv[c*8 +: 8]);
        wb = m_lfsr < p[15:8];           // R3
        m_lfsr = ref_step(m_lfsr);       // R2
        for (int r = 0; r < ROWS; r++) begin
          if (wb && cv[r*2 +: 2] == C_POT) m_w[r][c] = 1'b1;   // R4
          if (wb && cv[r*2 +: 2] == C_DEP) m_w[r][c] = 1'b0;
        end
      end
    end else begin
      logic [ROWS*SW-1:0] e;
      e = '0;
      for (int r = 0; r < ROWS; r++) begin
        logic [SW-1:0] s;
        s = '0;
        for (int c = 0; c < COLS; c++) if (m_w[r][c]) s = s + SW'(iv[c*8 +: 8]);
        e[r*SW +: SW] = s;               // R6
      end
      q_sum.push_back(e);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    train_mode = trn; in_vec = iv; learn_rate = rt; row_codes = cv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin                   // R8: ignored start and changed operands
      train_mode = !trn; in_vec = ~iv; learn_rate = ~rt; row_codes = ~cv; start = 1'b1;
    end
    for (int k = 1; k < COLS; k++) begin
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7 early done", 64'(done), 64'd0);
    end
    @(negedge clk);
    check(done == 1'b1, "R7 done timing", 64'(done), 64'd1);
    check(sum_valid == !trn, "R7 sum_valid phase", 64'(sum_valid), 64'(!trn));
    if (trn) check(sum_out == last_sums, "R9 sum_out held", 64'(sum_out), 64'(last_sums));
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
  endtask

  localparam logic [COLS*8-1:0] PROBE = {8'd8, 8'd4, 8'd2, 8'd1};
  localparam logic [COLS*8-1:0] FULL  = {8'd255, 8'd255, 8'd255, 8'd255};

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) m_w[r][c] = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && sum_valid == 1'b0, "R1 reset strobes", 64'({done, sum_valid}), 64'd0);
    check(sum_out == '0, "R1 reset sums", 64'(sum_out), 64'd0);
    rst = 1'b0;
    // R1: all weights low after reset
    run_pass(1'b0, FULL, 8'd0, '0, 1'b0, "R1 weights low after reset");
    // R4: potentiate, depress, hold and reserved codes at high probability
    run_pass(1'b1, FULL, 8'd255, {C_RSV, C_HOLD, C_DEP, C_POT}, 1'b0, "");
    run_pass(1'b0, PROBE, 8'd0, '0, 1'b0, "R4 codes applied");
    // R3: zero-input columns never written
    run_pass(1'b1, {8'd255, 8'd0, 8'd255, 8'd0}, 8'd255, {4{C_POT}}, 1'b0, "");
    run_pass(1'b0, PROBE, 8'd0, '0, 1'b0, "R3 zero input columns untouched");
    // R3: zero rate never writes
    run_pass(1'b1, FULL, 8'd0, {4{C_DEP}}, 1'b0, "");
    run_pass(1'b0, PROBE, 8'd0, '0, 1'b0, "R3 zero rate no write");
    // R5: recognition with active codes changes nothing
    run_pass(1'b0, FULL, 8'd255, {4{C_DEP}}, 1'b0, "R5 recognition with depress codes");
    run_pass(1'b0, PROBE, 8'd0, {4{C_POT}}, 1'b0, "R5 weights unchanged");
    // R8: disturbed operands and a start while busy
    run_pass(1'b1, {8'd200, 8'd90, 8'd255, 8'd30}, 8'd220, {C_DEP, C_POT, C_POT, C_DEP}, 1'b1, "");
    run_pass(1'b0, PROBE, 8'd0, '0, 1'b1, "R8 operands captured at start");
    // R2/R3/R4/R6: a run of pseudo-random passes against the model
    for (int i = 0; i < 24; i++) begin
      logic [COLS*8-1:0] iv;
      logic [ROWS*2-1:0] cv;
      seed = seed * 32'd1664525 + 32'd1013904223;
      iv = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      cv = seed[ROWS*2+3:4];
      run_pass(1'b1, iv, 8'd160 + 8'(i), cv, 1'b0, "");
      run_pass(1'b0, PROBE, 8'd0, '0, 1'b0, "R2 sequence drives weights");
    end
    // R6: full-scale boundary and mixed inputs
    run_pass(1'b0, FULL, 8'd0, '0, 1'b0, "R6 full-scale sums");
    run_pass(1'b0, {8'd17, 8'd250, 8'd3, 8'd128}, 8'd0, '0, 1'b0, "R6 mixed inputs");
    repeat (2) @(negedge clk);
    check(q_sum.size() == 0, "R7 missing results", 64'(q_sum.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule